// File: doc/BRIEF.md
# Cache AHB-Lite Burst Sequencer

This block sits between a cache controller and an AHB-Lite manager port. It turns two kinds of request into bus transfers. Line requests from the cache become incrementing bursts: a fill reads a whole line and an eviction writes one back. Uncached requests become single transfers: a read, a write, or an atomic read followed by a write. The block drives the transfer type, the burst code and the write flag. It also keeps a data-beat counter, so the cache can pick the word for each beat.

Each request input works like a valid that the requester must hold steady until the block pulses the matching acknowledge. That acknowledge pulse is the ready. The requester may drop or change the request only after the clock edge that samples the acknowledge. The subordinate applies back-pressure through `hready`. While `hready` is low, the block holds its address-phase outputs and the beat counter, and it pulses neither a capture enable nor an acknowledge. The block has no data path of its own. `capture_en` tells the requester when to latch read data, and the acknowledges tell it when a request has finished.

The request encoding is the same on both request inputs. Bit 1 means read and bit 0 means write. For `unc_rw`, 2'b10 is a read, 2'b01 is a write and 2'b11 is an atomic read-then-write. For `line_rw`, 2'b10 is a fill, 2'b01 is an eviction, and 2'b11 is an eviction with a fill still to follow.

Top module: `ahb_line_bus_fsm`

## Requirements
- R1: While `rst_n` is low, `htrans` is IDLE (2'b00), `hburst` is SINGLE (3'b000), `hwrite`, `capture_en`, `unc_ack`, `line_ack` and `final_beat` are 0, and `beat_idx` is 0.
- R2: An uncached read (`unc_rw`=2'b10) drives one NONSEQ (2'b10) SINGLE read address phase. The FSM stays in that phase while `hready` is low. After `hready` is seen high, one data phase follows with `htrans` IDLE, and `unc_ack` pulses in the data-phase cycle that has `hready` high.
- R3: An uncached write (`unc_rw`=2'b01) drives a NONSEQ SINGLE address phase with `hwrite`=1. It never raises `capture_en`. `unc_ack` waits in the data phase until `hready` is high.
- R4: While a transfer is offered (`htrans` not IDLE) and `hready` is low, `htrans`, `hwrite` and `hburst` keep their values into the next cycle.
- R5: A fill (`line_rw`=2'b10) drives NONSEQ on its first address. It then drives SEQ (2'b11) for each following address, and IDLE once the last address has been accepted. `hburst` is INCR4 (3'b011) for 4 words per line, INCR8 (3'b101) for 8, INCR16 (3'b111) for 16, and INCR (3'b001) for other line sizes.
- R6: `beat_idx` counts completed data beats of a burst and advances only in cycles with `hready` high. `final_beat` is 1 exactly when `beat_idx` equals the words per line minus one. The counter returns to 0 when the FSM goes back to the address phase.
- R7: `line_ack` pulses for one cycle, on the last beat of a burst with `hready` high, and never together with `unc_ack`.
- R8: An eviction (`line_rw` bit 0 set) runs the same burst sequence as a fill but with `hwrite`=1, and it never raises `capture_en`.
- R9: `capture_en` is 1 only in a read data phase (uncached read, fill beat, or the read half of an atomic) with `hready` high and `flush` low.
- R10: `flush` suppresses `capture_en` only. Transfer types, beat counting and acknowledges are unchanged.
- R11: An atomic (`unc_rw`=2'b11) issues a NONSEQ read. During that read's data phase it offers a NONSEQ write address, then runs the write data phase. It pulses `unc_ack` once, at the end of the write.
- R12: When both inputs request in the address phase, the line request goes first. Within `line_rw`, an eviction (bit 0) goes before a fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Blocks read-data capture in the current cycle |
| unc_rw | input | 2 | Uncached request: 10 read, 01 write, 11 atomic; held until `unc_ack` |
| line_rw | input | 2 | Line request: 10 fill, 01 evict, 11 evict then fill; held until `line_ack` |
| hready | input | 1 | Bus ready from the subordinate |
| htrans | output | 2 | Transfer type: IDLE 00, NONSEQ 10, SEQ 11 |
| hburst | output | 3 | Burst code |
| hwrite | output | 1 | Write transfer flag |
| capture_en | output | 1 | Latch read data this cycle |
| unc_ack | output | 1 | Uncached request complete |
| line_ack | output | 1 | Line burst complete |
| beat_idx | output | $clog2(LINE_WORDS) | Data beat index within the burst |
| final_beat | output | 1 | Current data beat is the last of the line |

## Verification
The bound checker watches some rules on every cycle: the address phase held stable under wait states, the beat counter frozen while `hready` is low, capture never without `hready` and with `flush` low, the one-hot acknowledges, and the counter restart after a line acknowledge. The scenario tasks are needed for the rest. They show the exact order of NONSEQ, SEQ and IDLE through a burst, the atomic read-to-write handover, that eviction goes ahead of a fill and line requests ahead of uncached ones, and that a flush leaves sequencing and acknowledges untouched. These depend on which request was presented, and the checker does not model that.

// File: rtl/ahbbus_pkg.sv
package ahbbus_pkg;
  typedef enum logic [2:0] {
    ST_ADDR   = 3'd0,
    ST_DATA   = 3'd1,
    ST_FILL   = 3'd2,
    ST_EVICT  = 3'd3,
    ST_AMO_RD = 3'd4
  } bus_state_e;

  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic [2:0] BU_SINGLE = 3'b000;
  localparam logic [2:0] BU_INCR   = 3'b001;
  localparam logic [2:0] BU_INCR4  = 3'b011;
  localparam logic [2:0] BU_INCR8  = 3'b101;
  localparam logic [2:0] BU_INCR16 = 3'b111;

  localparam logic [1:0] RQ_NONE  = 2'b00;
  localparam logic [1:0] RQ_READ  = 2'b10;
  localparam logic [1:0] RQ_WRITE = 2'b01;
  localparam logic [1:0] RQ_AMO   = 2'b11;
endpackage

// File: rtl/ahbbus_beat_ctr.sv
module ahbbus_beat_ctr #(
  parameter int LINE_WORDS = 4,
  parameter int BEAT_W     = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  output logic [BEAT_W-1:0] cnt,
  output logic              last
);
  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(LINE_WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (advance) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == LAST_IDX);
endmodule

// File: rtl/ahbbus_next_state.sv
module ahbbus_next_state
  import ahbbus_pkg::*;
(
  input  bus_state_e state,
  input  logic       hready,
  input  logic [1:0] unc_rw,
  input  logic [1:0] line_rw,
  input  logic       last,
  output bus_state_e next
);
  always_comb begin
    next = state;
    unique case (state)
      ST_ADDR: begin
        if (hready) begin
          // line traffic outranks uncached; eviction outranks fill
          if (line_rw != RQ_NONE)     next = line_rw[0] ? ST_EVICT : ST_FILL;
          else if (unc_rw == RQ_AMO)  next = ST_AMO_RD;
          else if (unc_rw != RQ_NONE) next = ST_DATA;
        end
      end
      ST_DATA:   if (hready) next = ST_ADDR;
      ST_AMO_RD: if (hready) next = ST_DATA;
      ST_FILL,
      ST_EVICT:  if (hready && last) next = ST_ADDR;
      default:   next = ST_ADDR;
    endcase
  end
endmodule

// File: rtl/ahbbus_drive.sv
module ahbbus_drive
  import ahbbus_pkg::*;
#(
  parameter int LINE_WORDS = 4
) (
  input  bus_state_e state,
  input  logic       hready,
  input  logic       flush,
  input  logic [1:0] unc_rw,
  input  logic [1:0] line_rw,
  input  logic       last,
  output logic [1:0] htrans,
  output logic [2:0] hburst,
  output logic       hwrite,
  output logic       capture_en,
  output logic       unc_ack,
  output logic       line_ack
);
  logic [2:0] line_burst;
  logic       read_phase;

  generate
    if (LINE_WORDS == 4) begin : g_incr4
      assign line_burst = BU_INCR4;
    end else if (LINE_WORDS == 8) begin : g_incr8
      assign line_burst = BU_INCR8;
    end else if (LINE_WORDS == 16) begin : g_incr16
      assign line_burst = BU_INCR16;
    end else begin : g_incr
      assign line_burst = BU_INCR;
    end
  endgenerate

  always_comb begin
    htrans     = TR_IDLE;
    hburst     = BU_SINGLE;
    hwrite     = 1'b0;
    read_phase = 1'b0;
    unc_ack    = 1'b0;
    line_ack   = 1'b0;
    unique case (state)
      ST_ADDR: begin
        if (line_rw != RQ_NONE) begin
          htrans = TR_NONSEQ;
          hburst = line_burst;
          hwrite = line_rw[0];
        end else if (unc_rw != RQ_NONE) begin
          htrans = TR_NONSEQ;
          hwrite = (unc_rw == RQ_WRITE);
        end
      end
      ST_DATA: begin
        read_phase = (unc_rw == RQ_READ);
        unc_ack    = hready;
      end
      ST_AMO_RD: begin
        // read data returns while the write address is offered
        htrans     = TR_NONSEQ;
        hwrite     = 1'b1;
        read_phase = 1'b1;
      end
      ST_FILL, ST_EVICT: begin
        htrans     = last ? TR_IDLE : TR_SEQ;
        hburst     = line_burst;
        hwrite     = (state == ST_EVICT);
        read_phase = (state == ST_FILL);
        line_ack   = hready & last;
      end
      default: ;
    endcase
  end

  assign capture_en = read_phase & hready & ~flush;
endmodule

// File: rtl/ahb_line_bus_fsm.sv
module ahb_line_bus_fsm
  import ahbbus_pkg::*;
#(
  parameter int LINE_WORDS = 4,
  parameter int BEAT_W     = $clog2(LINE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [1:0]        unc_rw,
  input  logic [1:0]        line_rw,
  input  logic              hready,
  output logic [1:0]        htrans,
  output logic [2:0]        hburst,
  output logic              hwrite,
  output logic              capture_en,
  output logic              unc_ack,
  output logic              line_ack,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              final_beat
);
  bus_state_e state, next;
  logic       in_burst;
  logic       last;
  logic       rst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_ADDR;
    else        state <= next;
  end

  assign in_burst = (state == ST_FILL) || (state == ST_EVICT);
  assign rst_q    = ~rst_n;

  ahbbus_beat_ctr #(.LINE_WORDS(LINE_WORDS), .BEAT_W(BEAT_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (next == ST_ADDR),
    .advance (in_burst & hready),
    .cnt     (beat_idx),
    .last    (last)
  );

  ahbbus_next_state u_nxt (
    .state   (state),
    .hready  (hready),
    .unc_rw  (unc_rw),
    .line_rw (line_rw),
    .last    (last),
    .next    (next)
  );

  ahbbus_drive #(.LINE_WORDS(LINE_WORDS)) u_drv (
    .state      (state),
    .hready     (hready),
    .flush      (flush),
    .unc_rw     (rst_q ? RQ_NONE : unc_rw),
    .line_rw    (rst_q ? RQ_NONE : line_rw),
    .last       (last),
    .htrans     (htrans),
    .hburst     (hburst),
    .hwrite     (hwrite),
    .capture_en (capture_en),
    .unc_ack    (unc_ack),
    .line_ack   (line_ack)
  );

  assign final_beat = in_burst & last;
endmodule

// File: rtl/ahb_line_bus_fsm_chk.sv
module ahb_line_bus_fsm_chk #(
  parameter int LINE_WORDS = 4,
  parameter int BEAT_W     = $clog2(LINE_WORDS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              hready,
  input logic [1:0]        htrans,
  input logic [2:0]        hburst,
  input logic              hwrite,
  input logic              capture_en,
  input logic              unc_ack,
  input logic              line_ack,
  input logic [BEAT_W-1:0] beat_idx,
  input logic              final_beat
);
  // R4: offered address phase is held under a wait state
  a_r4_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans != 2'b00 && !hready) |=>
      (htrans == $past(htrans) && hwrite == $past(hwrite) && hburst == $past(hburst)));

  // R5: sequential beats only inside a burst
  a_r5_seq_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans == 2'b11) |-> (hburst != 3'b000));

  // R6: counter frozen while the bus stalls
  a_r6_beat_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> (beat_idx == $past(beat_idx)));

  // R6: counter restarts after a line completes
  a_r6_beat_restart: assert property (@(posedge clk) disable iff (!rst_n)
    line_ack |=> (beat_idx == '0));

  // R7: line acknowledge only on an accepted final beat
  a_r7_line_ack: assert property (@(posedge clk) disable iff (!rst_n)
    line_ack |-> (final_beat && hready));

  // R7: acknowledges never overlap
  a_r7_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({unc_ack, line_ack}));

  // R9 / R10: capture needs ready and no flush
  a_r9_capture_gate: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |-> (hready && !flush));

  // R2: uncached completion happens with the bus idle
  a_r2_ack_idle: assert property (@(posedge clk) disable iff (!rst_n)
    unc_ack |-> (htrans == 2'b00 && hready));
endmodule

bind ahb_line_bus_fsm ahb_line_bus_fsm_chk #(
  .LINE_WORDS (LINE_WORDS),
  .BEAT_W     (BEAT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .hready     (hready),
  .htrans     (htrans),
  .hburst     (hburst),
  .hwrite     (hwrite),
  .capture_en (capture_en),
  .unc_ack    (unc_ack),
  .line_ack   (line_ack),
  .beat_idx   (beat_idx),
  .final_beat (final_beat)
);

// File: tb/ahb_line_bus_fsm_bench.sv
`timescale 1ns/1ps
module ahb_line_bus_fsm_bench;
  localparam int WORDS = 4;
  localparam logic [1:0] IDL = 2'b00, NSQ = 2'b10, SQ = 2'b11;
  localparam logic [2:0] SGL = 3'b000, I4 = 3'b011;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic [1:0] unc_rw = 2'b00;
  logic [1:0] line_rw = 2'b00;
  logic       hready = 1'b1;
  logic [1:0] htrans;
  logic [2:0] hburst;
  logic       hwrite, capture_en, unc_ack, line_ack, final_beat;
  logic [1:0] beat_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ahb_line_bus_fsm #(.LINE_WORDS(WORDS)) u_ahb_line_bus_fsm (
    .clk(clk), .rst_n(rst_n), .flush(flush), .unc_rw(unc_rw), .line_rw(line_rw),
    .hready(hready), .htrans(htrans), .hburst(hburst), .hwrite(hwrite),
    .capture_en(capture_en), .unc_ack(unc_ack), .line_ack(line_ack),
    .beat_idx(beat_idx), .final_beat(final_beat)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  // packed as {htrans, hwrite, hburst, capture_en, unc_ack, line_ack}
  task automatic expect_bus(string req, logic [1:0] tr, logic wr, logic [2:0] bu,
                            logic cap, logic ua, logic la);
    logic [8:0] act, exp;
    #1;
    act = {htrans, hwrite, hburst, capture_en, unc_ack, line_ack};
    exp = {tr, wr, bu, cap, ua, la};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: bus act=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic expect_beat(string req, int idx, logic fin);
    checks++;
    if (beat_idx !== 2'(idx) || final_beat !== fin) begin
      errors++;
      $display("FAIL %s: beat act=%0d/%b exp=%0d/%b", req, beat_idx, final_beat, idx, fin);
    end
  endtask

  // one full line burst; optional stall and flush on chosen beats
  task automatic run_line(string req, logic [1:0] rw, int stall_at, int flush_at,
                          logic [1:0] after);
    logic wr;
    wr = rw[0];
    line_rw = rw;
    expect_bus(req, NSQ, wr, I4, 0, 0, 0);
    cyc();
    for (int b = 0; b < WORDS; b++) begin
      if (b == stall_at) begin
        hready = 1'b0;
        expect_bus(req, (b == WORDS-1) ? IDL : SQ, wr, I4, 0, 0, 0);
        expect_beat(req, b, b == WORDS-1);
        cyc();
        hready = 1'b1;
      end
      flush = (b == flush_at);
      expect_bus(req, (b == WORDS-1) ? IDL : SQ, wr, I4,
                 !wr && (b != flush_at), 0, b == WORDS-1);
      expect_beat(req, b, b == WORDS-1);
      cyc();
      flush = 1'b0;
    end
    line_rw = after;
  endtask

  task automatic t_reset();
    unc_rw = 2'b10; line_rw = 2'b10;
    expect_bus("R1", IDL, 0, SGL, 0, 0, 0);
    expect_beat("R1", 0, 0);
    cyc();
    unc_rw = 2'b00; line_rw = 2'b00;
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic t_unc_read();
    unc_rw = 2'b10; hready = 1'b0;
    expect_bus("R2", NSQ, 0, SGL, 0, 0, 0);
    cyc();
    expect_bus("R4", NSQ, 0, SGL, 0, 0, 0);
    hready = 1'b1;
    expect_bus("R2", NSQ, 0, SGL, 0, 0, 0);
    cyc();
    expect_bus("R2", IDL, 0, SGL, 1, 1, 0);
    cyc();
    unc_rw = 2'b00;
    expect_bus("R2", IDL, 0, SGL, 0, 0, 0);
  endtask

  task automatic t_unc_write();
    unc_rw = 2'b01;
    expect_bus("R3", NSQ, 1, SGL, 0, 0, 0);
    cyc();
    hready = 1'b0;
    expect_bus("R3", IDL, 0, SGL, 0, 0, 0);
    cyc();
    hready = 1'b1;
    expect_bus("R3", IDL, 0, SGL, 0, 1, 0);
    cyc();
    unc_rw = 2'b00;
    expect_bus("R3", IDL, 0, SGL, 0, 0, 0);
  endtask

  task automatic t_fill();
    run_line("R5", 2'b10, 1, -1, 2'b00);
    expect_bus("R7", IDL, 0, SGL, 0, 0, 0);
    expect_beat("R6", 0, 0);
  endtask

  task automatic t_evict_then_fill();
    unc_rw = 2'b10;
    // R12: eviction bit first, line traffic ahead of the pending uncached read
    run_line("R12", 2'b11, 3, -1, 2'b10);
    run_line("R8", 2'b10, -1, -1, 2'b00);
    expect_bus("R12", NSQ, 0, SGL, 0, 0, 0);
    cyc();
    expect_bus("R12", IDL, 0, SGL, 1, 1, 0);
    cyc();
    unc_rw = 2'b00;
    expect_bus("R12", IDL, 0, SGL, 0, 0, 0);
  endtask

  task automatic t_flush();
    run_line("R10", 2'b10, -1, 2, 2'b00);
    expect_beat("R10", 0, 0);
    unc_rw = 2'b10; flush = 1'b1;
    expect_bus("R10", NSQ, 0, SGL, 0, 0, 0);
    cyc();
    expect_bus("R9", IDL, 0, SGL, 0, 1, 0);
    cyc();
    unc_rw = 2'b00; flush = 1'b0;
    expect_bus("R10", IDL, 0, SGL, 0, 0, 0);
  endtask

  task automatic t_atomic();
    unc_rw = 2'b11;
    expect_bus("R11", NSQ, 0, SGL, 0, 0, 0);
    cyc();
    hready = 1'b0;
    expect_bus("R11", NSQ, 1, SGL, 0, 0, 0);
    cyc();
    hready = 1'b1;
    expect_bus("R11", NSQ, 1, SGL, 1, 0, 0);
    cyc();
    expect_bus("R11", IDL, 0, SGL, 0, 1, 0);
    cyc();
    unc_rw = 2'b00;
    expect_bus("R11", IDL, 0, SGL, 0, 0, 0);
  endtask

  initial begin
    repeat (3) cyc();
    t_reset();
    t_unc_read();
    t_unc_write();
    t_fill();
    t_evict_then_fill();
    t_flush();
    t_atomic();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule